// File: doc/BRIEF.md
# Selectable Processor Clock with Single Step

This block turns a fast board clock into the clock of a small processor. It offers seven speed levels. Level 0 parks the clock high. Levels 1 to 6 run at roughly 0.24 Hz, 1 Hz, 2 Hz, 4 Hz, 15 Hz and 2 kHz. Two active-high buttons move the level down (left) or up (right) by one step for each debounced press. A third button, pause, drives the processor clock low for as long as it is held.

Pause combines with level 0 to give single-step execution. The clock is high at level 0. Holding pause pulls it low, and releasing pause lets it return high. That one rising edge advances the processor by exactly one cycle.

The board clock frequency is a parameter, and it must be at least 2 MHz in hardware. All dividers are sized from it. The output clock comes from a register, so a change of level or of pause never produces a runt pulse. For display, the block reports the level one-hot and also the present level of the processor clock.

Top module: `cpuclk_top`

## Requirements
- R1: At level L, for L from 1 to 6, `cpu_clk` is a square wave with a period of 2*H board cycles. H = max(1, floor(CLK_HZ*100 / (2*F))), where F in hundredths of a hertz is 24, 100, 200, 400, 1500 and 200000 for levels 1 to 6 respectively.
- R2: At level 0, with pause released, `cpu_clk` stays high.
- R3: While the debounced pause input is high, `cpu_clk` is low at every level.
- R4: At level 0, releasing pause after it has been held produces exactly one rising edge of `cpu_clk`, and the clock then stays high.
- R5: Each debounced press of the right button raises the level by one. Each debounced press of the left button lowers it by one.
- R6: The level saturates: a right press at level 6 leaves it at 6, and a left press at level 0 leaves it at 0.
- R7: A button pulse shorter than DB_CYCLES board cycles has no effect on the level or on pause.
- R8: Presses of left and right that become valid in the same cycle leave the level unchanged.
- R9: While reset is applied, the level is INIT_LEVEL (default 2) and `cpu_clk` is low.
- R10: Bit i of `level_onehot` is 1 exactly when the level is i, and `clk_level` always equals `cpu_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_board | input | 1 | Board clock, frequency CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_left | input | 1 | Lower speed button, active high, asynchronous |
| btn_right | input | 1 | Raise speed button, active high, asynchronous |
| btn_pause | input | 1 | Pause button, active high, asynchronous |
| cpu_clk | output | 1 | Selected processor clock |
| clk_level | output | 1 | Copy of the clock level for an indicator |
| level_onehot | output | 7 | Current speed level, one-hot |

## Verification
The bench builds the block with CLK_HZ = 4800 and DB_CYCLES = 4. With these values, every level's half period drops to between 1 and 10000 board cycles, so the test can measure the period of each level exactly and compare it with the formula of R1. A short debounce window makes sub-threshold glitches, simultaneous presses and saturation at both ends cheap to exercise. A second instance with INIT_LEVEL = 0 covers a non-default reset level and checks that the clock rises after reset without any button activity.

// File: rtl/cpuclk_pkg.sv
// Shared constants and helpers for the processor clock selector.
// Assumes levels are numbered 0..6, with level 0 being the static-high level.
package cpuclk_pkg;
    localparam int unsigned NUM_LEVELS = 7;
    localparam int unsigned LVL_W      = 3;

    // Target frequency of a level in hundredths of a hertz (level 0 unused).
    function automatic longint unsigned level_centihz(int unsigned lvl);
        case (lvl)
            1:       return 64'd24;
            2:       return 64'd100;
            3:       return 64'd200;
            4:       return 64'd400;
            5:       return 64'd1500;
            default: return 64'd200000;
        endcase
    endfunction

    // Board cycles per half period of a level, never below one.
    function automatic int unsigned half_cycles(int unsigned clk_hz, int unsigned lvl);
        longint unsigned h;
        h = (longint'(clk_hz) * 64'd100) / (64'd2 * level_centihz(lvl));
        if (h < 64'd1) h = 64'd1;
        return int'(h);
    endfunction
endpackage

// File: rtl/cpuclk_debounce.sv
// Button conditioner: two-flop synchronizer followed by a stability filter.
// The filtered level follows the input only once it has differed from the
// current filtered level for DB_CYCLES consecutive cycles; a pulse marks a
// filtered 0->1 transition. Assumes DB_CYCLES >= 1.
module cpuclk_debounce #(
    parameter int unsigned DB_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic press_o
);
    localparam int unsigned CW = $clog2(DB_CYCLES + 1);

    logic          sync1_q, sync2_q;
    logic          stable_q;
    logic          press_q;
    logic [CW-1:0] cnt_q;

    // Bring the asynchronous button into the board clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
        end
    end

    // Accept a new level only after it has held for the full window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
            cnt_q    <= '0;
            press_q  <= 1'b0;
        end else begin
            press_q <= 1'b0;
            if (sync2_q == stable_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(DB_CYCLES - 1)) begin
                cnt_q    <= '0;
                stable_q <= sync2_q;
                press_q  <= sync2_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level_o = stable_q;
    assign press_o = press_q;

    // R7: the filtered level never moves while the synchronized input agrees with it.
    a_r7_hold_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (sync2_q == stable_q) |=> $stable(stable_q));
endmodule

// File: rtl/cpuclk_divider.sv
// Free-running square-wave generator: toggles its output every HALF board
// cycles. Assumes HALF >= 1.
module cpuclk_divider #(
    parameter int unsigned HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic wave_o
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          wave_q;

    // Count a half period and flip the wave at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wave_q <= 1'b0;
        end else if (cnt_q == CW'(HALF - 1)) begin
            cnt_q  <= '0;
            wave_q <= ~wave_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wave_o = wave_q;

    // R1: the half-period counter stays inside its window.
    a_r1_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < HALF);
endmodule

// File: rtl/cpuclk_level.sv
// Speed level register: steps up or down by one per press pulse and
// saturates at 0 and MAX_LEVEL. Simultaneous pulses cancel.
module cpuclk_level #(
    parameter int unsigned LVL_W      = 3,
    parameter int unsigned MAX_LEVEL  = 6,
    parameter int unsigned INIT_LEVEL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             down_i,
    output logic [LVL_W-1:0] level_o
);
    logic [LVL_W-1:0] lvl_q;

    // Apply one saturating step per accepted press.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_W'(INIT_LEVEL);
        end else if (up_i && !down_i && lvl_q != LVL_W'(MAX_LEVEL)) begin
            lvl_q <= lvl_q + 1'b1;
        end else if (down_i && !up_i && lvl_q != '0) begin
            lvl_q <= lvl_q - 1'b1;
        end
    end

    assign level_o = lvl_q;

    // R6: the level never leaves the legal range.
    a_r6_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(lvl_q) <= MAX_LEVEL);
    // R5: an up press below the top moves exactly one step.
    a_r5_up_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && !down_i && lvl_q != LVL_W'(MAX_LEVEL)) |=> lvl_q == $past(lvl_q) + 1'b1);
    // R8: simultaneous presses leave the level alone.
    a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && down_i) |=> $stable(lvl_q));
endmodule

// File: rtl/cpuclk_top.sv
// Processor clock selector. Six dividers run continuously from the board
// clock; a registered multiplexer picks one by the current level, forces
// high at level 0 and low while pause is held. Assumes CLK_HZ >= 2 MHz in
// hardware and INIT_LEVEL in 0..6.
module cpuclk_top #(
    parameter int unsigned CLK_HZ     = 2000000,
    parameter int unsigned INIT_LEVEL = 2,
    parameter int unsigned DB_CYCLES  = 20000
) (
    input  logic       clk_board,
    input  logic       rst_n,
    input  logic       btn_left,
    input  logic       btn_right,
    input  logic       btn_pause,
    output logic       cpu_clk,
    output logic       clk_level,
    output logic [6:0] level_onehot
);
    import cpuclk_pkg::*;

    localparam int unsigned MAX_LEVEL = NUM_LEVELS - 1;

    logic [NUM_LEVELS-1:0] wave;
    logic                  up_p, down_p, pause_db;
    logic                  up_lvl_unused, down_lvl_unused, pause_p_unused;
    logic [LVL_W-1:0]      level;
    logic                  clk_q;

    assign wave[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 1; gi < NUM_LEVELS; gi++) begin : g_div
            cpuclk_divider #(.HALF(half_cycles(CLK_HZ, gi))) u_div (
                .clk    (clk_board),
                .rst_n  (rst_n),
                .wave_o (wave[gi])
            );
        end
    endgenerate

    cpuclk_debounce #(.DB_CYCLES(DB_CYCLES)) u_db_right (
        .clk(clk_board), .rst_n(rst_n), .raw_i(btn_right),
        .level_o(up_lvl_unused), .press_o(up_p));
    cpuclk_debounce #(.DB_CYCLES(DB_CYCLES)) u_db_left (
        .clk(clk_board), .rst_n(rst_n), .raw_i(btn_left),
        .level_o(down_lvl_unused), .press_o(down_p));
    cpuclk_debounce #(.DB_CYCLES(DB_CYCLES)) u_db_pause (
        .clk(clk_board), .rst_n(rst_n), .raw_i(btn_pause),
        .level_o(pause_db), .press_o(pause_p_unused));

    cpuclk_level #(
        .LVL_W(LVL_W), .MAX_LEVEL(MAX_LEVEL), .INIT_LEVEL(INIT_LEVEL)
    ) u_level (
        .clk(clk_board), .rst_n(rst_n),
        .up_i(up_p), .down_i(down_p), .level_o(level));

    // Register the selected clock so switching never emits a runt pulse.
    always_ff @(posedge clk_board) begin
        if (!rst_n) clk_q <= 1'b0;
        else        clk_q <= pause_db ? 1'b0 : wave[level];
    end

    assign cpu_clk   = clk_q;
    assign clk_level = clk_q;

    // Expand the level to a one-hot display vector.
    always_comb begin
        level_onehot = '0;
        level_onehot[level] = 1'b1;
    end

    // R3: a held pause keeps the clock low.
    a_r3_pause_low: assert property (@(posedge clk_board) disable iff (!rst_n)
        pause_db |=> !cpu_clk);
    // R2: level 0 without pause keeps the clock high.
    a_r2_idle_high: assert property (@(posedge clk_board) disable iff (!rst_n)
        (!pause_db && level == '0) |=> cpu_clk);
    // R10: exactly one display bit is lit.
    a_r10_onehot: assert property (@(posedge clk_board) disable iff (!rst_n)
        $countones(level_onehot) == 1);
endmodule

// File: tb/tb_cpuclk_top.sv
module tb_cpuclk_top;
    localparam int unsigned CLK_HZ = 4800;
    localparam int unsigned DB     = 4;
    localparam int unsigned SETTLE = DB + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bl = 1'b0, br = 1'b0, bp = 1'b0;
    logic cpu_clk, clk_level, cpu_clk2, clk_level2;
    logic [6:0] onehot, onehot2;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cpuclk_top #(.CLK_HZ(CLK_HZ), .INIT_LEVEL(2), .DB_CYCLES(DB)) dut (
        .clk_board(clk), .rst_n(rst_n), .btn_left(bl), .btn_right(br),
        .btn_pause(bp), .cpu_clk(cpu_clk), .clk_level(clk_level),
        .level_onehot(onehot));

    cpuclk_top #(.CLK_HZ(CLK_HZ), .INIT_LEVEL(0), .DB_CYCLES(DB)) dut2 (
        .clk_board(clk), .rst_n(rst_n), .btn_left(1'b0), .btn_right(1'b0),
        .btn_pause(1'b0), .cpu_clk(cpu_clk2), .clk_level(clk_level2),
        .level_onehot(onehot2));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int half_of(int lvl);
        longint f;
        longint h;
        case (lvl)
            1: f = 24; 2: f = 100; 3: f = 200; 4: f = 400; 5: f = 1500;
            default: f = 200000;
        endcase
        h = (longint'(CLK_HZ) * 100) / (2 * f);
        return (h < 1) ? 1 : int'(h);
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic press(ref logic b, input int hold);
        b = 1'b1; tick(hold);
        b = 1'b0; tick(SETTLE);
    endtask

    task automatic check_level(input int lvl, input string req);
        check(onehot == 7'(1 << lvl), req, onehot, 7'(1 << lvl));
        check(clk_level == cpu_clk, "R10 mirror", clk_level, cpu_clk);
    endtask

    // Cycles from one rising edge of cpu_clk to the next.
    task automatic measure(output int period);
        logic prev;
        int   n;
        period = -1;
        prev = cpu_clk;
        for (int i = 0; i < 30000; i++) begin
            tick(1);
            if (!prev && cpu_clk) break;
            prev = cpu_clk;
        end
        prev = cpu_clk;
        n = 0;
        for (int i = 0; i < 30000; i++) begin
            tick(1);
            n++;
            if (!prev && cpu_clk) begin period = n; break; end
            prev = cpu_clk;
        end
    endtask

    task automatic count_rises(input int n, output int rises, output int highs);
        logic prev;
        rises = 0; highs = 0;
        prev = cpu_clk;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (!prev && cpu_clk) rises++;
            if (cpu_clk) highs++;
            prev = cpu_clk;
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int p, r, h;
        tick(5);
        // R9: state while reset is applied
        check(onehot == 7'b0000100, "R9 level", onehot, 7'b0000100);
        check(cpu_clk == 1'b0, "R9 clk", cpu_clk, 0);
        check(onehot2 == 7'b0000001, "R9 init0", onehot2, 7'b0000001);
        rst_n = 1'b1;
        tick(3);
        check(cpu_clk2 == 1'b1, "R2 init0 high", cpu_clk2, 1);

        measure(p);
        check(p == 2 * half_of(2), "R1 level2", p, 2 * half_of(2));

        press(bl, SETTLE);
        check_level(1, "R5 left");
        press(bl, SETTLE);
        check_level(0, "R5 left");
        count_rises(100, r, h);
        check(h == 100, "R2 level0 high", h, 100);
        press(bl, SETTLE);
        check_level(0, "R6 floor");

        // R3/R4: single step at level 0
        bp = 1'b1; tick(SETTLE);
        count_rises(50, r, h);
        check(h == 0, "R3 pause low", h, 0);
        bp = 1'b0;
        count_rises(60, r, h);
        check(r == 1, "R4 one edge", r, 1);
        check(cpu_clk == 1'b1, "R4 stays high", cpu_clk, 1);
        bp = 1'b1; tick(2); bp = 1'b0;
        count_rises(40, r, h);
        check(h == 40, "R7 pause glitch", h, 40);

        for (int lvl = 1; lvl <= 6; lvl++) begin
            press(br, SETTLE);
            check_level(lvl, "R5 right");
            measure(p);
            check(p == 2 * half_of(lvl), "R1 period", p, 2 * half_of(lvl));
        end
        press(br, SETTLE);
        check_level(6, "R6 ceiling");
        press(bl, 2);
        check_level(6, "R7 left glitch");
        bl = 1'b1; br = 1'b1; tick(SETTLE);
        bl = 1'b0; br = 1'b0; tick(SETTLE);
        check_level(6, "R8 both");

        bp = 1'b1; tick(SETTLE);
        count_rises(40, r, h);
        check(h == 0, "R3 pause at 6", h, 0);
        bp = 1'b0; tick(SETTLE);
        measure(p);
        check(p == 2 * half_of(6), "R1 resume", p, 2 * half_of(6));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule